// File: doc/BRIEF.md
# Pointer-Selected Register Array

This block is a bank of sixteen 16-bit registers. Three 4-bit selectors choose which register plays which role. The program-pointer selector picks the register whose value is the current fetch address. The data-pointer selector picks the register that supplies the data address. The operand field of each opcode picks the register that the operation works on. Any register can take any of these roles, so software can switch the program counter or the data pointer by loading a selector instead of copying values around.

The block is driven by an 8-bit opcode that is qualified by a strobe. It decodes the register-operation opcodes:

- whole-register increment and decrement;
- increment of the data-pointer register;
- byte transfers in both directions between an 8-bit accumulator port and either half of a register;
- selector loads for the program and data pointers;
- store-and-decrement, which presents the accumulator value and the data-pointer address as a memory write and then steps that register down.

Memory, the arithmetic unit and branching live outside this block.

All read paths are combinational from the selectors and the opcode. Registers and selectors change only on a clock edge that the strobe qualifies. Reset clears both selectors and register 0. After reset, register 0 therefore serves as both the program counter and the data pointer, and it holds the address 0.

Top module: `reg_pointer_array`

## Requirements
- R1: While `rst_n` is low, and after its release, `p_sel`, `x_sel`, `pc_addr` and `data_addr` are all 0, and register 0 reads back as 16'h0000. Opcodes are accepted from the second rising edge after `rst_n` rises.
- R2: A strobed opcode 8'h1n (n is the low nibble) adds one to register n at the clock edge. 16'hFFFF wraps to 16'h0000.
- R3: A strobed opcode 8'h2n subtracts one from register n at the clock edge. 16'h0000 wraps to 16'hFFFF.
- R4: A strobed opcode 8'h60 adds one, modulo 65536, to the register chosen by `x_sel`.
- R5: While opcode 8'h8n is strobed, `d_we` is 1 and `d_out` shows bits 7:0 of register n, combinationally. No register changes.
- R6: While opcode 8'h9n is strobed, `d_we` is 1 and `d_out` shows bits 15:8 of register n, combinationally.
- R7: A strobed opcode 8'hAn writes `d_in` into bits 7:0 of register n, and opcode 8'hBn writes `d_in` into bits 15:8. The other byte keeps its value.
- R8: While opcode 8'h73 is strobed, `st_we` is 1, `st_addr` equals the register chosen by `x_sel`, and `st_data` equals `d_in`. At the clock edge that register is decremented, modulo 65536.
- R9: A strobed opcode 8'hDn sets `p_sel` to n. `pc_addr` always shows the register chosen by `p_sel`.
- R10: A strobed opcode 8'hEn sets `x_sel` to n. `data_addr` always shows the register chosen by `x_sel`.
- R11: Any other opcode, and any opcode presented with `op_valid` low, changes no register and no selector, and leaves `d_we` and `st_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Strobe that qualifies `op_code` for this cycle |
| op_code | input | 8 | Opcode: high nibble is the operation, low nibble the register number |
| d_in | input | 8 | Accumulator value, used by byte loads and stores |
| d_out | output | 8 | Selected byte for the accumulator |
| d_we | output | 1 | High while a byte-read opcode is strobed |
| pc_addr | output | 16 | Register chosen by the program-pointer selector |
| data_addr | output | 16 | Register chosen by the data-pointer selector |
| st_we | output | 1 | Memory write request for store-and-decrement |
| st_addr | output | 16 | Memory write address |
| st_data | output | 8 | Memory write data |
| p_sel | output | 4 | Program-pointer selector |
| x_sel | output | 4 | Data-pointer selector |

## Verification
The bench first loads every register with a distinct value built from its index. It then reads back both bytes of all sixteen registers. This separates the byte lanes and reveals any register aliasing.

Increment and decrement are applied to each register in turn, and once each to the boundaries 16'hFFFF and 16'h0000, to catch a wrong step direction or a missing wrap.

Both selectors are swept over every value:

- the program-pointer sweep shows that `pc_addr` follows the chosen register;
- for each data-pointer value, one increment shows that the step hits the chosen register and no other;
- a store-and-decrement of register 0 holding 16'h0000 shows the write request and the wrap.

A final pass presents unsupported opcodes, and a valid opcode with the strobe low, then re-reads every register and selector to show that nothing moved.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

  typedef enum logic [3:0] {
    K_NONE,
    K_INC_N,
    K_DEC_N,
    K_INC_X,
    K_GET_LO,
    K_GET_HI,
    K_PUT_LO,
    K_PUT_HI,
    K_STORE_DEC,
    K_SET_P,
    K_SET_X
  } op_kind_e;

  typedef struct packed {
    op_kind_e    kind;
    logic [3:0]  sel;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [7:0] op);
    op_dec_t r;
    r.sel  = op[3:0];
    r.kind = K_NONE;
    case (op[7:4])
      4'h1: r.kind = K_INC_N;
      4'h2: r.kind = K_DEC_N;
      4'h6: if (op[3:0] == 4'h0) r.kind = K_INC_X;
      4'h7: if (op[3:0] == 4'h3) r.kind = K_STORE_DEC;
      4'h8: r.kind = K_GET_LO;
      4'h9: r.kind = K_GET_HI;
      4'hA: r.kind = K_PUT_LO;
      4'hB: r.kind = K_PUT_HI;
      4'hD: r.kind = K_SET_P;
      4'hE: r.kind = K_SET_X;
      default: r.kind = K_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rpa_rst_sync.sv
module rpa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rpa_decode.sv
module rpa_decode
  import rpa_pkg::*;
(
  input  logic        op_valid,
  input  logic [7:0]  op_code,
  output op_dec_t     dec
);
  op_dec_t raw;

  always_comb begin
    raw = decode_op(op_code);
    dec = raw;
    if (!op_valid) dec.kind = K_NONE;
  end
endmodule

// File: rtl/rpa_incdec.sv
module rpa_incdec #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         down,
  output logic [W-1:0] res
);
  always_comb begin
    if (down) res = val - W'(1);
    else      res = val + W'(1);
  end
endmodule

// File: rtl/rpa_regbank.sv
module rpa_regbank #(
  parameter int REGS = 16,
  parameter int W    = 16,
  parameter int IDXW = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [W-1:0]    wr_data,
  input  logic [IDXW-1:0] rd_a_idx,
  input  logic [IDXW-1:0] rd_b_idx,
  input  logic [IDXW-1:0] rd_c_idx,
  output logic [W-1:0]    rd_a,
  output logic [W-1:0]    rd_b,
  output logic [W-1:0]    rd_c
);
  localparam int HALF = W / 2;

  logic [REGS-1:0][W-1:0] view;

  for (genvar gi = 0; gi < REGS; gi++) begin : g_reg
    logic [W-1:0] q;
    logic [W-1:0] nxt;
    logic         hit;
    logic         en;

    assign hit = (wr_idx == IDXW'(gi));
    assign en  = hit && (wr_lo || wr_hi);

    always_comb begin
      nxt = q;
      if (wr_lo) nxt[HALF-1:0] = wr_data[HALF-1:0];
      if (wr_hi) nxt[W-1:HALF] = wr_data[W-1:HALF];
    end

    if (gi == 0) begin : g_rst
      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n)  q <= '0;
        else if (en)  q <= nxt;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (en) q <= nxt;
      end
    end

    assign view[gi] = q;
  end

  assign rd_a = view[rd_a_idx];
  assign rd_b = view[rd_b_idx];
  assign rd_c = view[rd_c_idx];
endmodule

// File: rtl/reg_pointer_array.sv
module reg_pointer_array
  import rpa_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int REG_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid,
  input  logic [7:0]                   op_code,
  input  logic [REG_W/2-1:0]           d_in,
  output logic [REG_W/2-1:0]           d_out,
  output logic                         d_we,
  output logic [REG_W-1:0]             pc_addr,
  output logic [REG_W-1:0]             data_addr,
  output logic                         st_we,
  output logic [REG_W-1:0]             st_addr,
  output logic [REG_W/2-1:0]           st_data,
  output logic [$clog2(REG_COUNT)-1:0] p_sel,
  output logic [$clog2(REG_COUNT)-1:0] x_sel
);
  localparam int IDXW = $clog2(REG_COUNT);
  localparam int HALF = REG_W / 2;

  logic            srst_n;
  op_dec_t         dec;
  logic [IDXW-1:0] p_q, p_nxt, x_q, x_nxt;
  logic            p_en, x_en;
  logic [IDXW-1:0] tgt_idx;
  logic [REG_W-1:0] tgt_val, stepped, wr_data;
  logic            is_step, step_down, wr_lo, wr_hi;

  rpa_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rpa_decode u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .dec      (dec)
  );

  // selector next state
  always_comb begin
    p_en  = (dec.kind == K_SET_P);
    x_en  = (dec.kind == K_SET_X);
    p_nxt = IDXW'(dec.sel);
    x_nxt = IDXW'(dec.sel);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      p_q <= '0;
      x_q <= '0;
    end else begin
      if (p_en) p_q <= p_nxt;
      if (x_en) x_q <= x_nxt;
    end
  end

  // register write control
  always_comb begin
    is_step   = (dec.kind == K_INC_N) || (dec.kind == K_DEC_N) ||
                (dec.kind == K_INC_X) || (dec.kind == K_STORE_DEC);
    step_down = (dec.kind == K_DEC_N) || (dec.kind == K_STORE_DEC);
    if ((dec.kind == K_INC_X) || (dec.kind == K_STORE_DEC)) tgt_idx = x_q;
    else                                                  tgt_idx = IDXW'(dec.sel);
    wr_lo   = is_step || (dec.kind == K_PUT_LO);
    wr_hi   = is_step || (dec.kind == K_PUT_HI);
    wr_data = is_step ? stepped : {d_in, d_in};
  end

  rpa_incdec #(.W(REG_W)) u_step (
    .val  (tgt_val),
    .down (step_down),
    .res  (stepped)
  );

  rpa_regbank #(.REGS(REG_COUNT), .W(REG_W), .IDXW(IDXW)) u_bank (
    .clk      (clk),
    .srst_n   (srst_n),
    .wr_idx   (tgt_idx),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .rd_a_idx (tgt_idx),
    .rd_b_idx (p_q),
    .rd_c_idx (x_q),
    .rd_a     (tgt_val),
    .rd_b     (pc_addr),
    .rd_c     (data_addr)
  );

  // output side
  always_comb begin
    d_we    = (dec.kind == K_GET_LO) || (dec.kind == K_GET_HI);
    d_out   = (dec.kind == K_GET_HI) ? tgt_val[REG_W-1:HALF] : tgt_val[HALF-1:0];
    st_we   = (dec.kind == K_STORE_DEC);
    st_addr = data_addr;
    st_data = d_in;
    p_sel   = p_q;
    x_sel   = x_q;
  end
endmodule

// File: rtl/rpa_chk.sv
module rpa_chk #(
  parameter int W    = 16,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            srst_n,
  input logic            op_valid,
  input logic [7:0]      op_code,
  input logic [W-1:0]    pc_addr,
  input logic [W-1:0]    data_addr,
  input logic [W-1:0]    st_addr,
  input logic            st_we,
  input logic            d_we,
  input logic [IDXW-1:0] p_sel,
  input logic [IDXW-1:0] x_sel
);
  // R2
  inc_p_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && op_code[7:4] == 4'h1 && op_code[3:0] == 4'(p_sel))
      |=> pc_addr == $past(pc_addr) + W'(1));

  // R3
  dec_x_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && op_code[7:4] == 4'h2 && op_code[3:0] == 4'(x_sel))
      |=> data_addr == $past(data_addr) - W'(1));

  // R4
  inc_x_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && op_code == 8'h60) |=> data_addr == $past(data_addr) + W'(1));

  // R8
  store_dec_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && op_code == 8'h73) |=> data_addr == $past(st_addr) - W'(1));

  // R9
  set_p_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && op_code[7:4] == 4'hD) |=> 4'(p_sel) == $past(op_code[3:0]));

  // R10
  set_x_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && op_code[7:4] == 4'hE) |=> 4'(x_sel) == $past(op_code[3:0]));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !op_valid |=> $stable(pc_addr) && $stable(data_addr) && $stable(p_sel) && $stable(x_sel));

  // R11
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !op_valid |-> !st_we && !d_we);
endmodule

bind reg_pointer_array rpa_chk #(.W(REG_W), .IDXW($clog2(REG_COUNT))) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .pc_addr   (pc_addr),
  .data_addr (data_addr),
  .st_addr   (st_addr),
  .st_we     (st_we),
  .d_we      (d_we),
  .p_sel     (p_sel),
  .x_sel     (x_sel)
);

// File: tb/test_reg_pointer_array.sv
module test_reg_pointer_array;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  op_code;
  logic [7:0]  d_in;
  logic [7:0]  d_out;
  logic        d_we;
  logic [15:0] pc_addr, data_addr, st_addr;
  logic        st_we;
  logic [7:0]  st_data;
  logic [3:0]  p_sel, x_sel;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [15:0] model [16];

  always #4 clk = ~clk;

  reg_pointer_array i_reg_pointer_array (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .d_in(d_in), .d_out(d_out), .d_we(d_we), .pc_addr(pc_addr),
    .data_addr(data_addr), .st_we(st_we), .st_addr(st_addr),
    .st_data(st_data), .p_sel(p_sel), .x_sel(x_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [7:0] op, input logic [7:0] d);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; d_in = d;
    @(negedge clk);
    op_valid = 1'b0; op_code = 8'h00;
  endtask

  task automatic peek(input logic [7:0] op, output logic [7:0] val, output logic we);
    @(negedge clk);
    op_valid = 1'b1; op_code = op;
    #1;
    val = d_out; we = d_we;
    op_valid = 1'b0; op_code = 8'h00;
  endtask

  task automatic write_reg(input int n, input logic [15:0] v);
    do_op(8'hA0 | 8'(n), v[7:0]);
    do_op(8'hB0 | 8'(n), v[15:8]);
  endtask

  task automatic read_reg(input int n, output logic [15:0] v);
    logic [7:0] lo, hi;
    logic we_lo, we_hi;
    peek(8'h80 | 8'(n), lo, we_lo);
    peek(8'h90 | 8'(n), hi, we_hi);
    v = {hi, lo};
  endtask

  task automatic check_reg(input string req, input int n);
    logic [15:0] v;
    read_reg(n, v);
    chk(req, v, model[n]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic        w;
    logic [15:0] v;
    rst_n = 1'b0; op_valid = 1'b0; op_code = 8'h00; d_in = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 p_sel", p_sel, 0);
    chk("R1 x_sel", x_sel, 0);
    chk("R1 pc_addr", pc_addr, 0);
    chk("R1 data_addr", data_addr, 0);
    chk("R11 st_we idle", st_we, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_reg(0, v);
    chk("R1 reg0", v, 0);

    // load all registers, R7
    for (int i = 0; i < 16; i++) begin
      model[i] = 16'(i * 16'h1357) ^ 16'hA0C5;
      write_reg(i, model[i]);
    end
    // R7 byte-only writes keep the other half
    do_op(8'hA3, 8'h99);
    model[3] = {model[3][15:8], 8'h99};
    check_reg("R7 low byte", 3);
    do_op(8'hB3, 8'h55);
    model[3] = {8'h55, model[3][7:0]};
    check_reg("R7 high byte", 3);

    // R5 R6 read every byte
    for (int i = 0; i < 16; i++) begin
      peek(8'h80 | 8'(i), b, w);
      chk("R5 low byte", {w, b}, {1'b1, model[i][7:0]});
      peek(8'h90 | 8'(i), b, w);
      chk("R6 high byte", {w, b}, {1'b1, model[i][15:8]});
    end

    // R2 increment sweep
    for (int i = 0; i < 16; i++) begin
      do_op(8'h10 | 8'(i), 8'h00);
      model[i] = model[i] + 16'd1;
      check_reg("R2 inc", i);
    end
    // R3 decrement sweep
    for (int i = 0; i < 16; i++) begin
      do_op(8'h20 | 8'(i), 8'h00);
      model[i] = model[i] - 16'd1;
      check_reg("R3 dec", i);
    end
    // R2 R3 wrap
    write_reg(5, 16'hFFFF);
    do_op(8'h15, 8'h00);
    model[5] = 16'h0000;
    check_reg("R2 wrap", 5);
    do_op(8'h25, 8'h00);
    model[5] = 16'hFFFF;
    check_reg("R3 wrap", 5);

    // R9 program pointer selection
    for (int i = 0; i < 16; i++) begin
      do_op(8'hD0 | 8'(i), 8'h00);
      chk("R9 p_sel", p_sel, i);
      chk("R9 pc_addr", pc_addr, model[i]);
    end
    do_op(8'hD4, 8'h00);
    do_op(8'h14, 8'h00);
    model[4] = model[4] + 16'd1;
    chk("R2 inc of program pointer", pc_addr, model[4]);

    // R10 R4 data pointer selection and increment
    for (int i = 0; i < 16; i++) begin
      do_op(8'hE0 | 8'(i), 8'h00);
      chk("R10 x_sel", x_sel, i);
      chk("R10 data_addr", data_addr, model[i]);
      do_op(8'h60, 8'h00);
      model[i] = model[i] + 16'd1;
      chk("R4 inc x", data_addr, model[i]);
    end
    for (int i = 0; i < 16; i++) check_reg("R4 no stray write", i);

    // R8 store and decrement
    do_op(8'hE9, 8'h00);
    @(negedge clk);
    op_valid = 1'b1; op_code = 8'h73; d_in = 8'h3C;
    #1;
    chk("R8 st_we", st_we, 1);
    chk("R8 st_addr", st_addr, model[9]);
    chk("R8 st_data", st_data, 8'h3C);
    @(negedge clk);
    op_valid = 1'b0; op_code = 8'h00;
    model[9] = model[9] - 16'd1;
    chk("R8 decrement", data_addr, model[9]);
    write_reg(0, 16'h0000);
    model[0] = 16'h0000;
    do_op(8'hE0, 8'h00);
    do_op(8'h73, 8'h11);
    model[0] = 16'hFFFF;
    chk("R8 wrap", data_addr, 16'hFFFF);

    // R11 unsupported opcodes and strobe low
    do_op(8'hD7, 8'h00);
    do_op(8'hEB, 8'h00);
    foreach (model[k]) begin end
    begin
      logic [7:0] ign [13] = '{8'h00, 8'h30, 8'h3F, 8'h40, 8'h5A, 8'h61,
                               8'h68, 8'h70, 8'h74, 8'hC4, 8'hF0, 8'hFF, 8'h7F};
      for (int j = 0; j < 13; j++) begin
        @(negedge clk);
        op_valid = 1'b1; op_code = ign[j]; d_in = 8'hE7;
        #1;
        chk("R11 no strobes", {d_we, st_we}, 2'b00);
        @(negedge clk);
        op_valid = 1'b0; op_code = 8'h00;
      end
    end
    @(negedge clk);
    op_code = 8'h15; d_in = 8'h42;
    #1;
    chk("R11 strobe low d_we", d_we, 0);
    @(negedge clk);
    op_code = 8'hA5;
    @(negedge clk);
    op_code = 8'hD2;
    @(negedge clk);
    op_code = 8'h00;
    chk("R11 p_sel held", p_sel, 7);
    chk("R11 x_sel held", x_sel, 11);
    for (int i = 0; i < 16; i++) check_reg("R11 registers held", i);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule